// File: doc/BRIEF.md
# VGA Frame Scan and Frame-Buffer Read Address Generator

This block times a video frame of 800 pixel clocks per line and 512 lines per frame, and produces the two active-low sync signals, a colour output enable, and the read address of a frame buffer whose data goes straight to a colour DAC. Two free-running counters track the clock within the line and the line within the frame. A column counter steps once every two clocks inside a fixed horizontal window, so each stored pixel is shown as two screen pixels and a line holds 256 stored columns.

The read address joins the column, the line number, a page bit supplied by control logic and a bank bit taken from a static strap into one 19-bit word. The last 32 lines of each frame are blank. During them the block raises a level signal, and on their first clock it pulses a strobe, so that an outside write engine can take over the memory while nothing is displayed.

Top module: `vga_scan_addr`

## Requirements
- R1: Every line lasts exactly 800 clocks. `hsync_n` is low on clocks 0 to 69 of each line and high on the rest.
- R2: A frame has 512 lines, numbered 0 to 511. `vsync_n` is low on lines 0 and 1 and high on all other lines.
- R3: The visible window covers clocks 118 to 629 of each line, which is 48 clocks after `hsync_n` rises. Inside the window the column field `rd_addr[7:0]` equals (clock - 118) / 2, rounded down. Outside the window the field is 0.
- R4: `pix_oe` is never high while `hsync_n` or `vsync_n` is low.
- R5: `pix_oe` is high exactly when the line is in 2..479, the clock is inside the window, and the column is not 255.
- R6: Inside the window the column holds for two clocks and then increases by one, running from 0 to 255.
- R7: `rd_addr` is {`bank_sel` at bit 18, `page_sel` at bit 17, line number at bits 16:8, column at bits 7:0}. Both select inputs reach the address in the same cycle.
- R8: Column 255 is never displayed: `pix_oe` is low on both of its clocks on every line.
- R9: `wr_window` is high on lines 480 to 511 and low on all other lines. `wr_grant_stb` is high for exactly one clock, on clock 0 of line 480.
- R10: While `rst_n` is low at a clock edge, the counters load line 0, clock 0. On the first cycle after release, `hsync_n` and `vsync_n` are low and the line field of the address is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Synchronous reset, active low |
| bank_sel | input | 1 | Static bank strap, becomes the address MSB |
| page_sel | input | 1 | Page bit from control logic |
| hsync_n | output | 1 | Horizontal sync, active low |
| vsync_n | output | 1 | Vertical sync, active low |
| pix_oe | output | 1 | Colour output enable |
| rd_addr | output | 19 | Frame-buffer read address |
| wr_window | output | 1 | High on the blank lines reserved for writes |
| wr_grant_stb | output | 1 | One-clock pulse at the start of the blank lines |

## Verification
All outputs are decoded from registers with no extra output stage. Each result therefore belongs to the same cycle as the counter state after the most recent edge, and the select inputs reach the address without delay. The bench keeps its own line and clock counters. It advances them at the same rising edge as the design, and at the following falling edge it compares every output with the value computed from those counters and the inputs currently applied. Frame-level events such as the blank-line strobe and the vertical wrap also run on a second, scaled-down instance, so that they occur many times within the run.

// File: rtl/vga_scan_addr.sv
module vga_scan_addr #(
  parameter int LINE_CLKS   = 800,
  parameter int HSYNC_CLKS  = 70,
  parameter int H_LEAD      = 48,
  parameter int COL_W       = 8,
  parameter int FRAME_LINES = 512,
  parameter int VIS_LINES   = 480,
  parameter int VSYNC_LINES = 2,
  parameter int ROW_W       = 9
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   bank_sel,
  input  logic                   page_sel,
  output logic                   hsync_n,
  output logic                   vsync_n,
  output logic                   pix_oe,
  output logic [COL_W+ROW_W+1:0] rd_addr,
  output logic                   wr_window,
  output logic                   wr_grant_stb
);
  localparam int HC_W    = $clog2(LINE_CLKS);
  localparam int VC_W    = $clog2(FRAME_LINES);
  localparam int ACT0    = HSYNC_CLKS + H_LEAD;
  localparam int ACT_END = ACT0 + 2 * (1 << COL_W);

  localparam logic [HC_W-1:0]  H_LAST  = HC_W'(LINE_CLKS - 1);
  localparam logic [HC_W-1:0]  H_SYNCE = HC_W'(HSYNC_CLKS);
  localparam logic [HC_W-1:0]  H_ACT0  = HC_W'(ACT0);
  localparam logic [HC_W-1:0]  H_ACTE  = HC_W'(ACT_END);
  localparam logic [VC_W-1:0]  V_LAST  = VC_W'(FRAME_LINES - 1);
  localparam logic [VC_W-1:0]  V_SYNCE = VC_W'(VSYNC_LINES);
  localparam logic [VC_W-1:0]  V_VISE  = VC_W'(VIS_LINES);
  localparam logic [COL_W-1:0] COL_MAX = '1;

  logic [HC_W-1:0]  hcnt;
  logic [VC_W-1:0]  vcnt;
  logic [COL_W-1:0] col;
  logic             half;
  logic             in_win;
  logic             vis_line;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hcnt <= '0;
      vcnt <= '0;
    end else if (hcnt == H_LAST) begin
      hcnt <= '0;
      vcnt <= (vcnt == V_LAST) ? '0 : vcnt + 1'b1;
    end else begin
      hcnt <= hcnt + 1'b1;
    end
  end

  assign in_win = (hcnt >= H_ACT0) && (hcnt < H_ACTE);

  always_ff @(posedge clk) begin
    if (!rst_n || !in_win) begin
      col  <= '0;
      half <= 1'b0;
    end else begin
      half <= ~half;
      if (half) col <= col + 1'b1;
    end
  end

  assign vis_line     = (vcnt >= V_SYNCE) && (vcnt < V_VISE);
  assign hsync_n      = hcnt >= H_SYNCE;
  assign vsync_n      = vcnt >= V_SYNCE;
  assign pix_oe       = in_win && vis_line && (col != COL_MAX) && hsync_n && vsync_n;
  assign wr_window    = vcnt >= V_VISE;
  assign wr_grant_stb = (vcnt == V_VISE) && (hcnt == '0);
  assign rd_addr      = {bank_sel, page_sel, ROW_W'(vcnt), col};
endmodule

// File: rtl/vga_scan_addr_chk.sv
module vga_scan_addr_chk #(
  parameter int LINE_CLKS = 800,
  parameter int COL_W     = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             hsync_n,
  input logic             vsync_n,
  input logic             pix_oe,
  input logic [COL_W-1:0] col,
  input logic             wr_window,
  input logic             wr_grant_stb
);
  logic hs_q;
  logic seen;
  int   since;
  logic hs_fell;

  assign hs_fell = hs_q && !hsync_n;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hs_q  <= 1'b0;
      seen  <= 1'b0;
      since <= 0;
    end else begin
      hs_q  <= hsync_n;
      if (hs_fell) seen <= 1'b1;
      since <= hs_fell ? 1 : since + 1;
    end
  end

  p_line_len_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (hs_fell && seen) |-> since == LINE_CLKS);

  p_oe_sync_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!hsync_n || !vsync_n) |-> !pix_oe);

  p_oe_blank_r5: assert property (@(posedge clk) disable iff (!rst_n)
    wr_window |-> !pix_oe);

  p_col_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (pix_oe && $past(pix_oe)) |-> (col == $past(col) || col == $past(col) + COL_W'(1)));

  p_last_col_r8: assert property (@(posedge clk) disable iff (!rst_n)
    pix_oe |-> col != {COL_W{1'b1}});

  p_stb_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
    wr_grant_stb |=> !wr_grant_stb);

  p_stb_in_win_r9: assert property (@(posedge clk) disable iff (!rst_n)
    wr_grant_stb |-> wr_window);
endmodule

bind vga_scan_addr vga_scan_addr_chk #(.LINE_CLKS(LINE_CLKS), .COL_W(COL_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .hsync_n(hsync_n), .vsync_n(vsync_n), .pix_oe(pix_oe),
  .col(rd_addr[COL_W-1:0]), .wr_window(wr_window), .wr_grant_stb(wr_grant_stb)
);

// File: tb/vga_scan_addr_tb.sv
module vga_scan_addr_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int RUN_CYCLES = 96000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bank_sel = 1'b0;
  logic page_sel = 1'b0;

  logic        hs_b, vs_b, oe_b, ww_b, stb_b;
  logic [18:0] addr_b;
  logic        hs_s, vs_s, oe_s, ww_s, stb_s;
  logic [8:0]  addr_s;

  int total = 0;
  int bad   = 0;
  int hb = 0, vb = 0, hsm = 0, vsm = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  vga_scan_addr dut_i (
    .clk(clk), .rst_n(rst_n), .bank_sel(bank_sel), .page_sel(page_sel),
    .hsync_n(hs_b), .vsync_n(vs_b), .pix_oe(oe_b), .rd_addr(addr_b),
    .wr_window(ww_b), .wr_grant_stb(stb_b));

  vga_scan_addr #(
    .LINE_CLKS(40), .HSYNC_CLKS(6), .H_LEAD(4), .COL_W(3),
    .FRAME_LINES(16), .VIS_LINES(12), .VSYNC_LINES(2), .ROW_W(4)
  ) dut_s (
    .clk(clk), .rst_n(rst_n), .bank_sel(bank_sel), .page_sel(page_sel),
    .hsync_n(hs_s), .vsync_n(vs_s), .pix_oe(oe_s), .rd_addr(addr_s),
    .wr_window(ww_s), .wr_grant_stb(stb_s));

  always @(posedge clk) begin
    if (!rst_n) begin
      hb <= 0; vb <= 0; hsm <= 0; vsm <= 0;
    end else begin
      hb <= (hb == 799) ? 0 : hb + 1;
      if (hb == 799) vb <= (vb == 511) ? 0 : vb + 1;
      hsm <= (hsm == 39) ? 0 : hsm + 1;
      if (hsm == 39) vsm <= (vsm == 15) ? 0 : vsm + 1;
    end
  end

  task automatic one(input string req, input string what, input longint act, input longint exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h (t=%0t)", req, what, act, exp, $time);
    end
  endtask

  function automatic int exp_col(int h, int a0, int cw);
    if (h >= a0 && h < a0 + 2 * (1 << cw)) return (h - a0) / 2;
    return 0;
  endfunction

  task automatic check_all(input string nm, input int h, input int v,
                           input int hsc, input int lead, input int cw, input int rw,
                           input int vis, input int vsl,
                           input logic hs, input logic vs, input logic oe,
                           input logic ww, input logic stb, input longint addr);
    int a0, c;
    bit win;
    longint ea;
    a0  = hsc + lead;
    win = (h >= a0) && (h < a0 + 2 * (1 << cw));
    c   = exp_col(h, a0, cw);
    one({"R1 ", nm}, "hsync_n", hs, (h >= hsc));
    one({"R2 ", nm}, "vsync_n", vs, (v >= vsl));
    one({"R3 R6 ", nm}, "column", addr & ((64'd1 << cw) - 1), c);
    if ((!hs || !vs) && oe) one({"R4 ", nm}, "pix_oe in sync", oe, 0);
    if (win && c == (1 << cw) - 1) one({"R8 ", nm}, "pix_oe on last column", oe, 0);
    else one({"R5 ", nm}, "pix_oe", oe, win && v >= vsl && v < vis);
    ea = longint'(c) | (longint'(v) << cw) | (longint'(page_sel) << (cw + rw))
       | (longint'(bank_sel) << (cw + rw + 1));
    one({"R7 ", nm}, "rd_addr", addr, ea);
    one({"R9 ", nm}, "wr_window", ww, (v >= vis));
    one({"R9 ", nm}, "wr_grant_stb", stb, (v == vis && h == 0));
  endtask

  task automatic check_cycle();
    check_all("full", hb, vb, 70, 48, 8, 9, 480, 2,
              hs_b, vs_b, oe_b, ww_b, stb_b, longint'(addr_b));
    check_all("small", hsm, vsm, 6, 4, 3, 4, 12, 2,
              hs_s, vs_s, oe_s, ww_s, stb_s, longint'(addr_s));
  endtask

  task automatic check_after_reset();
    one("R10", "hsync_n after reset", hs_b, 0);
    one("R10", "vsync_n after reset", vs_b, 0);
    one("R10", "line field after reset", (addr_b >> 8) & 19'h1ff, 0);
    one("R10", "small hsync_n after reset", hs_s, 0);
    one("R10", "small line field after reset", (addr_s >> 3) & 9'hf, 0);
  endtask

  initial begin
    void'($urandom(32'd2024));
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check_after_reset();
    check_cycle();
    for (int n = 1; n < RUN_CYCLES; n++) begin
      if (n % 7000 == 0) bank_sel = ~bank_sel;
      if ($urandom % 4 == 0) page_sel = $urandom % 2;
      if (n == 61234) begin
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check_after_reset();
      end else begin
        @(negedge clk);
      end
      check_cycle();
    end
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 200000);
    total++;
    bad++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule